// File: doc/BRIEF.md
# IPv4 Forwarding Header Processor

This block sits in the per-packet path of a small multi-port router. It watches a stream of 32-bit words, one per cycle, on a data/ctrl bus with a write strobe and a ready signal. It parses the base IPv4 header that starts each packet and decides the packet's fate: forward in hardware, hand to the CPU as an exception, or drop. Words flow through in the cycle they are accepted. The only word it changes is the one holding the time-to-live and the header checksum. Upstream logic removes the link-layer header, so the first packet word is the first IPv4 header word.

A word with a nonzero ctrl value other than the end code is a module header word. Such words come before the packet and are passed on untouched. Packet words carry ctrl zero, except the last, which carries the end code (default 0x01). When the header qualifies, the block decrements TTL in the third header word and updates the checksum incrementally on the fly. One cycle after the fifth header word it presents a 2-bit verdict and the destination address for the route lookup stage.

Top module: `ipv4_fwd_hdr_proc`

## Requirements
- R1: Every word written while out_rdy is high appears on out_data/out_ctrl/out_wr in the same cycle with ctrl unchanged. in_rdy follows out_rdy. Data is unchanged except the rewritten header word of R9.
- R2: Words whose ctrl is nonzero and not the end code pass through unchanged and do not count as IPv4 header words.
- R3: The header words are counted from the first packet word (ctrl 0 or end code). Word 0 holds version [31:28] and header length in 32-bit words [27:24]. Word 2 holds TTL [31:24], protocol [23:16] and checksum [15:0]. Word 4 is the destination address.
- R4: The verdict codes are 00 forward, 01 CPU and 10 drop. verdict_vld rises in the cycle after header word 4 is accepted. While it stays high, verdict and dst_addr hold steady. It falls after the edge that accepts the final word. If word 4 is itself final, it is high for one cycle.
- R5: While verdict_vld is high, dst_addr equals header word 4 of that packet.
- R6: A version other than 4 or a header length other than 5 gives verdict 01 whatever the checksum, and word 2 is not modified.
- R7: With a well-formed header, the header passes when the ones-complement sum of the ten 16-bit halves of words 0-4 folds to 0xFFFF. Otherwise the verdict is 10.
- R8: A well-formed header with a valid checksum and TTL of 0 or 1 gives verdict 01, and word 2 leaves unmodified.
- R9: A well-formed header with TTL of 2 or more leaves with TTL reduced by one and the protocol unchanged. Its checksum is updated so that a valid input header stays valid. With a valid checksum the verdict is 00.
- R10: A packet whose final word arrives before header word 4 gets verdict 10, valid for one cycle.
- R11: Cycles with in_wr low, including stalls with out_rdy low, do not advance the header parse or change a held verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Incoming word |
| in_ctrl | input | CTRL_W | Incoming word type |
| in_wr | input | 1 | Incoming word is valid |
| in_rdy | output | 1 | Block can accept a word |
| out_data | output | 32 | Outgoing word (rewritten when R9 applies) |
| out_ctrl | output | CTRL_W | Outgoing word type |
| out_wr | output | 1 | Outgoing word is valid |
| out_rdy | input | 1 | Downstream can accept a word |
| verdict | output | 2 | Packet decision code |
| verdict_vld | output | 1 | verdict and dst_addr are valid |
| dst_addr | output | 32 | Destination address for the lookup stage |

## Verification
The assertions assume that upstream raises in_wr only while in_rdy is high. They also assume that module header words come only before a packet's first word, so that the header count starts cleanly. The bench drives each word at the falling edge. During a stall it lowers out_rdy and keeps in_wr low. It builds every packet as module header words, then five header words, then payload words, and it also sends some deliberately short packets. Within that envelope it sweeps every TTL value, every version and every header length. It also sends corrupted checksums and compares the results with fields and sums it computes itself.

// File: rtl/ipv4_fwd_pkg.sv
package ipv4_fwd_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_WORDS = 5;
  localparam int IDX_W     = 3;

  typedef enum logic [1:0] {
    VERD_FWD  = 2'b00,
    VERD_CPU  = 2'b01,
    VERD_DROP = 2'b10
  } verdict_e;

  // ones-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // fold both halves of a 32-bit word into a running sum
  function automatic logic [15:0] oc_add_word(input logic [15:0] sum, input logic [WORD_W-1:0] w);
    return oc_add16(oc_add16(sum, w[31:16]), w[15:0]);
  endfunction

  // incremental checksum update for one changed 16-bit field
  function automatic logic [15:0] csum_patch(input logic [15:0] hc, input logic [15:0] old_f,
                                             input logic [15:0] new_f);
    return ~oc_add16(oc_add16(~hc, ~old_f), new_f);
  endfunction

  function automatic verdict_e pick_verdict(input logic [3:0] ver, input logic [3:0] ihl,
                                            input logic sum_ok, input logic [7:0] ttl);
    if (ver != 4'd4 || ihl != 4'd5) return VERD_CPU;
    if (!sum_ok)                     return VERD_DROP;
    if (ttl <= 8'd1)                 return VERD_CPU;
    return VERD_FWD;
  endfunction
endpackage

// File: rtl/ipv4_csum_acc.sv
module ipv4_csum_acc
  import ipv4_fwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic              first,
  input  logic [WORD_W-1:0] word,
  output logic [15:0]       sum_nxt
);
  logic [15:0] sum_q;
  logic [15:0] base;

  assign base    = first ? 16'h0000 : sum_q;
  assign sum_nxt = oc_add_word(base, word);

  always_ff @(posedge clk) begin
    if (!rst_n)      sum_q <= 16'h0000;
    else if (add_en) sum_q <= sum_nxt;
  end
endmodule

// File: rtl/ipv4_ttl_rewrite.sv
module ipv4_ttl_rewrite
  import ipv4_fwd_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              allow,
  output logic [WORD_W-1:0] word_out,
  output logic              fired
);
  logic [7:0]  ttl_old;
  logic [7:0]  ttl_new;
  logic [7:0]  proto;
  logic [15:0] csum_new;

  assign ttl_old  = word_in[31:24];
  assign proto    = word_in[23:16];
  assign ttl_new  = ttl_old - 8'd1;
  assign fired    = allow && (ttl_old > 8'd1);
  assign csum_new = csum_patch(word_in[15:0], {ttl_old, proto}, {ttl_new, proto});
  assign word_out = fired ? {ttl_new, proto, csum_new} : word_in;
endmodule

// File: rtl/ipv4_fwd_hdr_proc.sv
module ipv4_fwd_hdr_proc
  import ipv4_fwd_pkg::*;
#(
  parameter int              CTRL_W   = 8,
  parameter logic [CTRL_W-1:0] EOP_CODE = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_wr,
  output logic              in_rdy,
  output logic [31:0]       out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              out_wr,
  input  logic              out_rdy,
  output logic [1:0]        verdict,
  output logic              verdict_vld,
  output logic [31:0]       dst_addr
);
  localparam logic [IDX_W-1:0] IDX_TTL  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_PAST = IDX_W'(HDR_WORDS);

  // named events, also observed by the bound checker
  logic acc_w, is_final_w, is_mod_w, hdr_word_w, hdr_first_w, hdr_last_w;
  logic short_end_w, rew_allow_w, rew_fired_w, sum_ok_w;
  logic [15:0] sum_nxt_w;

  logic [IDX_W-1:0] idx_q;
  logic [3:0]       ver_q, ihl_q;
  logic [7:0]       ttl_q;
  logic             vld_q, done_q;
  verdict_e         code_q;
  logic [31:0]      dst_q;

  assign acc_w       = in_wr & out_rdy;
  assign is_final_w  = (in_ctrl == EOP_CODE);
  assign is_mod_w    = (in_ctrl != '0) && !is_final_w;
  assign hdr_word_w  = acc_w && !is_mod_w && (idx_q < IDX_PAST);
  assign hdr_first_w = hdr_word_w && (idx_q == '0);
  assign hdr_last_w  = hdr_word_w && (idx_q == IDX_LAST);
  assign short_end_w = acc_w && is_final_w && (idx_q < IDX_LAST);
  assign rew_allow_w = hdr_word_w && (idx_q == IDX_TTL) && (ver_q == 4'd4) && (ihl_q == 4'd5);
  assign sum_ok_w    = (sum_nxt_w == 16'hFFFF);

  ipv4_csum_acc u_csum (
    .clk    (clk),
    .rst_n  (rst_n),
    .add_en (hdr_word_w),
    .first  (hdr_first_w),
    .word   (in_data),
    .sum_nxt(sum_nxt_w)
  );

  ipv4_ttl_rewrite u_rew (
    .word_in (in_data),
    .allow   (rew_allow_w),
    .word_out(out_data),
    .fired   (rew_fired_w)
  );

  assign in_rdy   = out_rdy;
  assign out_wr   = in_wr;
  assign out_ctrl = in_ctrl;

  // header word counter and captured fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ver_q <= 4'd0;
      ihl_q <= 4'd0;
      ttl_q <= 8'd0;
    end else begin
      if (acc_w && !is_mod_w) begin
        if (is_final_w)           idx_q <= '0;
        else if (idx_q < IDX_PAST) idx_q <= idx_q + IDX_W'(1);
      end
      if (hdr_first_w) begin
        ver_q <= in_data[31:28];
        ihl_q <= in_data[27:24];
      end
      if (hdr_word_w && idx_q == IDX_TTL) ttl_q <= in_data[31:24];
    end
  end

  // verdict register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      code_q <= VERD_FWD;
      dst_q  <= 32'd0;
    end else if (hdr_last_w) begin
      vld_q  <= 1'b1;
      done_q <= is_final_w;
      code_q <= pick_verdict(ver_q, ihl_q, sum_ok_w, ttl_q);
      dst_q  <= in_data;
    end else if (short_end_w) begin
      vld_q  <= 1'b1;
      done_q <= 1'b1;
      code_q <= VERD_DROP;
    end else if (vld_q && done_q) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (vld_q && acc_w && is_final_w) begin
      vld_q  <= 1'b0;
    end
  end

  assign verdict     = code_q;
  assign verdict_vld = vld_q;
  assign dst_addr    = dst_q;
endmodule

// File: rtl/ipv4_fwd_hdr_proc_chk.sv
module ipv4_fwd_hdr_proc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] in_data,
  input logic        in_wr,
  input logic        in_rdy,
  input logic [31:0] out_data,
  input logic        out_wr,
  input logic [1:0]  verdict,
  input logic        verdict_vld,
  input logic [31:0] dst_addr,
  input logic        hdr_last_evt,
  input logic        short_end_evt,
  input logic        rewrite_evt
);
  AST_WR_ONLY_WHEN_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr |-> in_rdy); // R1
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && !rewrite_evt) |-> (out_wr && out_data == in_data)); // R1
  AST_TTL_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_evt |-> (out_data[31:24] == in_data[31:24] - 8'd1 && out_data[23:16] == in_data[23:16])); // R9
  AST_NO_EXPIRED_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_evt |-> (in_data[31:24] > 8'd1)); // R8
  AST_VERDICT_AFTER_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_last_evt |=> verdict_vld); // R4
  AST_VERDICT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |-> (verdict != 2'b11)); // R4
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_vld && $past(verdict_vld) && !$past(hdr_last_evt) && !$past(short_end_evt))
      |-> ($stable(verdict) && $stable(dst_addr))); // R11
  AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    short_end_evt |=> (verdict_vld && verdict == 2'b10)); // R10
  AST_DST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_last_evt |=> (dst_addr == $past(in_data))); // R5
endmodule

bind ipv4_fwd_hdr_proc ipv4_fwd_hdr_proc_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_data      (in_data),
  .in_wr        (in_wr),
  .in_rdy       (in_rdy),
  .out_data     (out_data),
  .out_wr       (out_wr),
  .verdict      (verdict),
  .verdict_vld  (verdict_vld),
  .dst_addr     (dst_addr),
  .hdr_last_evt (hdr_last_w),
  .short_end_evt(short_end_w),
  .rewrite_evt  (rew_fired_w)
);

// File: tb/ipv4_fwd_hdr_proc_tb_top.sv
module ipv4_fwd_hdr_proc_tb_top;
  localparam logic [7:0] EOP  = 8'h01;
  localparam logic [7:0] MODH = 8'hFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_wr = 1'b0;
  logic        in_rdy;
  logic [31:0] out_data;
  logic [7:0]  out_ctrl;
  logic        out_wr;
  logic        out_rdy = 1'b1;
  logic [1:0]  verdict;
  logic        verdict_vld;
  logic [31:0] dst_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ipv4_fwd_hdr_proc dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
    .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
    .out_rdy(out_rdy), .verdict(verdict), .verdict_vld(verdict_vld), .dst_addr(dst_addr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // 32-bit accumulate, then two folds
  function automatic logic [15:0] hsum(input logic [31:0] a, input logic [31:0] b,
                                       input logic [31:0] c, input logic [31:0] d,
                                       input logic [31:0] e);
    logic [31:0] s;
    s = a[31:16] + a[15:0] + b[31:16] + b[15:0] + c[31:16] + c[15:0]
      + d[31:16] + d[15:0] + e[31:16] + e[15:0];
    s = s[15:0] + s[31:16];
    s = s[15:0] + s[31:16];
    return s[15:0];
  endfunction

  // drive one word at the falling edge, sample, cross the rising edge
  task automatic put(input logic [31:0] d, input logic [7:0] c, output logic [31:0] od);
    in_data = d; in_ctrl = c; in_wr = 1'b1;
    #1;
    od = out_data;
    chk("R1", "out_ctrl", 32'(out_ctrl), 32'(c));
    chk("R1", "out_wr", 32'(out_wr), 32'd1);
    @(posedge clk); @(negedge clk);
    in_wr = 1'b0; in_ctrl = '0;
  endtask

  task automatic stall(input logic exp_vld, input logic [1:0] exp_code);
    out_rdy = 1'b0;
    #1;
    chk("R1", "in_rdy during stall", 32'(in_rdy), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R11", "vld over stall", 32'(verdict_vld), 32'(exp_vld));
    if (exp_vld) chk("R11", "code over stall", 32'(verdict), 32'(exp_code));
    out_rdy = 1'b1;
  endtask

  task automatic send_pkt(input logic [3:0] ver, input logic [3:0] ihl, input logic [7:0] ttl,
                          input logic [7:0] proto, input bit bad, input int nmod,
                          input int npay, input bit dostall);
    logic [31:0] hw [5];
    logic [31:0] ow [5];
    logic [31:0] od;
    logic [1:0]  exp_code;
    bit          fmt_ok, exp_rw;
    string       rq;
    hw[0] = {ver, ihl, 8'h00, 16'(20 + 4 * npay)};
    hw[1] = {8'hA5, ttl, 16'h4000};
    hw[2] = {ttl, proto, 16'h0000};
    hw[3] = {8'd10, proto, ttl, 8'd7};
    hw[4] = {8'd172, 8'd16, proto ^ 8'h3C, ttl};
    hw[2][15:0] = ~hsum(hw[0], hw[1], hw[2], hw[3], hw[4]);
    if (bad) hw[2][15:0] = hw[2][15:0] ^ 16'h0101;
    fmt_ok = (ver == 4'd4) && (ihl == 4'd5);
    exp_rw = fmt_ok && (ttl > 8'd1);
    if (!fmt_ok)          begin exp_code = 2'b01; rq = "R6"; end
    else if (bad)         begin exp_code = 2'b10; rq = "R7"; end
    else if (ttl <= 8'd1) begin exp_code = 2'b01; rq = "R8"; end
    else                  begin exp_code = 2'b00; rq = "R9"; end

    for (int k = 0; k < nmod; k++) begin
      put(32'hC0DE_0000 + 32'(k), MODH, od);
      chk("R2", "module header word", od, 32'hC0DE_0000 + 32'(k));
    end
    for (int i = 0; i < 5; i++) begin
      if (dostall && i == 3) stall(1'b0, 2'b00);
      put(hw[i], (i == 4 && npay == 0) ? EOP : 8'h00, ow[i]);
    end
    for (int i = 0; i < 5; i++)
      if (i != 2) chk("R3", "header word passes", ow[i], hw[i]);
    if (exp_rw) begin
      chk("R9", "ttl decremented", 32'(ow[2][31:24]), 32'(ttl - 8'd1));
      chk("R9", "protocol kept", 32'(ow[2][23:16]), 32'(proto));
      if (!bad) chk("R9", "rewritten header sum", 32'(hsum(ow[0], ow[1], ow[2], ow[3], ow[4])),
                    32'h0000_FFFF);
    end else begin
      chk(fmt_ok ? "R8" : "R6", "word 2 untouched", ow[2], hw[2]);
    end
    chk("R4", "verdict valid after word 4", 32'(verdict_vld), 32'd1);
    chk(rq, "verdict code", 32'(verdict), 32'(exp_code));
    chk("R5", "destination", dst_addr, hw[4]);

    for (int p = 0; p < npay; p++) begin
      if (dostall && p == 0) stall(1'b1, exp_code);
      put(32'hD000_0000 + 32'(p) + {24'd0, ttl}, (p == npay - 1) ? EOP : 8'h00, od);
      chk("R1", "payload passes", od, 32'hD000_0000 + 32'(p) + {24'd0, ttl});
      if (p != npay - 1) chk("R4", "verdict held", 32'({verdict_vld, verdict}), 32'({1'b1, exp_code}));
    end
    if (npay == 0) begin
      @(posedge clk); @(negedge clk);
    end
    chk("R4", "verdict clears after final word", 32'(verdict_vld), 32'd0);
  endtask

  task automatic send_short(input int nw);
    logic [31:0] od;
    logic [31:0] w;
    for (int i = 0; i < nw; i++) begin
      w = (i == 0) ? 32'h4500_0014 : ((i == 2) ? 32'h0111_0000 : 32'h1234_0000 + 32'(i));
      put(w, (i == nw - 1) ? EOP : 8'h00, od);
      chk("R10", "short word passes", od, w);
    end
    chk("R10", "short vld", 32'(verdict_vld), 32'd1);
    chk("R10", "short code drop", 32'(verdict), 32'h2);
    @(posedge clk); @(negedge clk);
    chk("R10", "short vld one cycle", 32'(verdict_vld), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4", "reset verdict_vld", 32'(verdict_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4", "idle verdict_vld", 32'(verdict_vld), 32'd0);
    chk("R1", "in_rdy follows out_rdy", 32'(in_rdy), 32'd1);

    // every TTL, valid checksum
    for (int t = 0; t < 256; t++)
      send_pkt(4'd4, 4'd5, 8'(t), 8'(t * 7), 1'b0, t % 3, t % 4, (t % 5) == 0);
    // corrupted checksum
    for (int t = 0; t < 12; t++)
      send_pkt(4'd4, 4'd5, 8'(t * 23), 8'd6, 1'b1, t % 2, t % 3, (t % 4) == 1);
    // every version other than 4
    for (int v = 0; v < 16; v++)
      if (v != 4) send_pkt(4'(v), 4'd5, 8'd64, 8'd17, v[0], 1, v % 3, v[1]);
    // every header length other than 5
    for (int h = 0; h < 16; h++)
      if (h != 5) send_pkt(4'd4, 4'(h), 8'd9, 8'd1, h[0], 0, h % 2, h[1]);
    // packets ending inside the header
    for (int n = 1; n < 5; n++) send_short(n);
    // one more full packet after short ones
    send_pkt(4'd4, 4'd5, 8'd200, 8'd6, 1'b0, 2, 1, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule